// File: doc/BRIEF.md
# Relative Countdown Alarm

This block is an alarm timer that counts down a relative interval rather than comparing against a calendar. Software loads a packed word holding days, hours, minutes and seconds, sets a run bit, and from then on every one-cycle pulse on `tick` (one per second in a real system) takes one second off the interval. The borrow crosses fields in mixed radix. When the interval reaches zero the block latches a pending flag and stops. The pending flag reaches the `irq` pin only while the interrupt-enable bit is set. Software clears the flag by writing a one to it.

Sequencing is held in a three-state machine. `ST_OFF` is the state while the run bit is clear. `ST_COUNT` is the state while the run bit is set and the interval is nonzero. `ST_HALT` is the state while the run bit is set and the interval is zero. The transitions are:
- arm: OFF to COUNT or HALT, when the run bit is seen set. The target depends on whether the interval is zero.
- expire: COUNT to HALT, on the tick that takes the interval to zero, or after a zero word is written.
- reload: HALT to COUNT, when a nonzero word is written.
- disarm: COUNT or HALT to OFF, when the run bit is cleared.

The state follows the run bit one cycle after that bit is written.

Top module: `alarm_countdown`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: The interval word is at offset 0x0C. Its fields are seconds in bits [5:0], minutes in [13:8], hours in [20:16] and days in [28:21]. The word reads back exactly as written within those fields, and all other bits read zero.
- R3: On each counted tick the interval loses one second. A seconds field at 0 becomes 59 and borrows from minutes. Minutes at 0 become 59 and borrow from hours. Hours at 0 become 23 and borrow from days.
- R4: Bit 8 of the register at 0x14 is the run bit. Ticks while it is 0 leave the interval unchanged. Clearing it mid-count freezes the interval and does not set pending.
- R5: The tick that takes the interval to zero sets pending, which is bit 0 at 0x1C. Later ticks leave the interval at zero.
- R6: Writing 1 to bit 0 at 0x1C clears pending. Writing 0 there leaves it set. If an expiry and a clear fall in the same cycle, the expiry wins.
- R7: `irq` is high exactly when pending is set and bit 0 of the register at 0x18 is set.
- R8: Writing zero to the interval word cancels the interval. Running with a zero interval never sets pending.
- R9: The day field holds intervals of up to 255 days.
- R10: A tick in the first cycle after the run-bit write lands is not counted. Ticks from the following cycle onward are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, one per second |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wen | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| irq | output | 1 | Alarm interrupt |

## Verification
The countdown is driven from a table of starting intervals, each followed by a tick count. The patterns are:
- a plain seconds decrement;
- one borrow from each of the minute, hour and day fields;
- an interval that lands exactly on zero;
- an interval that receives more ticks than it holds;
- an interval mixing all four fields;
- the full 255-day load.

Together these separate a wrong field radix from a borrow that stops too early or reaches too far. They also separate a counter that stops at zero from one that wraps. Directed cases cover the following: ticks with the run bit clear, freezing mid-count, cancelling by a zero write, the clear-on-one status bit with both data values, interrupt gating, and the uncounted tick right after the run bit is set.

// File: rtl/alarm_cd_pkg.sv
package alarm_cd_pkg;

    localparam int WORD_W  = 32;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HR_W    = 5;
    localparam int DAY_W   = 8;

    // Field positions inside the interval word (software decodes these)
    localparam int SEC_LSB = 0;
    localparam int MIN_LSB = 8;
    localparam int HR_LSB  = 16;
    localparam int DAY_LSB = 21;

    // Reload values when a field borrows
    localparam int SEC_TOP = 59;
    localparam int MIN_TOP = 59;
    localparam int HR_TOP  = 23;

    localparam logic [7:0] OFS_COUNT  = 8'h0C;
    localparam logic [7:0] OFS_RUN    = 8'h14;
    localparam logic [7:0] OFS_IRQEN  = 8'h18;
    localparam logic [7:0] OFS_STATUS = 8'h1C;
    localparam int         RUN_BIT    = 8;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } interval_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } run_state_t;

    function automatic interval_t unpack_word(input logic [WORD_W-1:0] w);
        interval_t v;
        v.sc  = w[SEC_LSB +: SEC_W];
        v.mn  = w[MIN_LSB +: MIN_W];
        v.hr  = w[HR_LSB  +: HR_W];
        v.day = w[DAY_LSB +: DAY_W];
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input interval_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEC_LSB +: SEC_W] = v.sc;
        w[MIN_LSB +: MIN_W] = v.mn;
        w[HR_LSB  +: HR_W]  = v.hr;
        w[DAY_LSB +: DAY_W] = v.day;
        return w;
    endfunction

endpackage

// File: rtl/alarm_cd_decr.sv
module alarm_cd_decr
    import alarm_cd_pkg::*;
(
    input  interval_t cur,
    output interval_t nxt,
    output logic      cur_zero,
    output logic      nxt_zero
);

    // Mixed-radix one-second decrement; borrow ripples upward field by field
    always_comb begin
        nxt = cur;
        if (cur.sc != '0) begin
            nxt.sc = cur.sc - SEC_W'(1);
        end else begin
            nxt.sc = SEC_W'(SEC_TOP);
            if (cur.mn != '0) begin
                nxt.mn = cur.mn - MIN_W'(1);
            end else begin
                nxt.mn = MIN_W'(MIN_TOP);
                if (cur.hr != '0) begin
                    nxt.hr = cur.hr - HR_W'(1);
                end else begin
                    nxt.hr  = HR_W'(HR_TOP);
                    nxt.day = cur.day - DAY_W'(1);
                end
            end
        end
        cur_zero = (cur == '0);
        nxt_zero = (nxt == '0);
    end

endmodule

// File: rtl/alarm_cd_fsm.sv
module alarm_cd_fsm
    import alarm_cd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       cnt_wr,
    input  logic       cur_zero,
    input  logic       nxt_zero,
    output run_state_t state,
    output logic       dec_fire,
    output logic       expire
);

    run_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (run) state_nx = cur_zero ? ST_HALT : ST_COUNT;   // arm
            end
            ST_COUNT: begin
                if (!run)          state_nx = ST_OFF;                // disarm
                else if (cur_zero) state_nx = ST_HALT;               // expire
            end
            ST_HALT: begin
                if (!run)           state_nx = ST_OFF;               // disarm
                else if (!cur_zero) state_nx = ST_COUNT;             // reload
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // Outputs: a tick counts only in COUNT with run set, no load this cycle
    always_comb begin
        dec_fire = (state == ST_COUNT) && run && tick && !cnt_wr && !cur_zero;
        expire   = dec_fire && nxt_zero;
    end

endmodule

// File: rtl/alarm_cd_regs.sv
module alarm_cd_regs
    import alarm_cd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dec_fire,
    input  interval_t         dec_val,
    input  logic              expire,
    output interval_t         cnt_q,
    output logic              run_q,
    output logic              ie_q,
    output logic              pend_q,
    output logic              cnt_wr,
    output logic              pend_clr,
    output logic [DATA_W-1:0] reg_rdata
);

    logic sel_cnt, sel_run, sel_ie, sel_sta;

    always_comb begin
        sel_cnt  = (reg_addr == ADDR_W'(OFS_COUNT));
        sel_run  = (reg_addr == ADDR_W'(OFS_RUN));
        sel_ie   = (reg_addr == ADDR_W'(OFS_IRQEN));
        sel_sta  = (reg_addr == ADDR_W'(OFS_STATUS));
        cnt_wr   = reg_wen && sel_cnt;
        pend_clr = reg_wen && sel_sta && reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cnt_wr)        cnt_q <= unpack_word(WORD_W'(reg_wdata));
            else if (dec_fire) cnt_q <= dec_val;
            if (reg_wen && sel_run) run_q <= reg_wdata[RUN_BIT];
            if (reg_wen && sel_ie)  ie_q  <= reg_wdata[0];
            // expiry has priority over a simultaneous clear
            if (expire)        pend_q <= 1'b1;
            else if (pend_clr) pend_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_cnt)      reg_rdata = DATA_W'(pack_word(cnt_q));
        else if (sel_run) reg_rdata[RUN_BIT] = run_q;
        else if (sel_ie)  reg_rdata[0] = ie_q;
        else if (sel_sta) reg_rdata[0] = pend_q;
    end

endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
    import alarm_cd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    interval_t         cnt_q, dec_val;
    logic              run_q, ie_q, pend_q, cnt_wr, pend_clr;
    logic              cur_zero, nxt_zero, dec_fire, expire;
    run_state_t        state;
    logic [WORD_W-1:0] cnt_word;

    alarm_cd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .dec_fire(dec_fire), .dec_val(dec_val), .expire(expire),
        .cnt_q(cnt_q), .run_q(run_q), .ie_q(ie_q), .pend_q(pend_q),
        .cnt_wr(cnt_wr), .pend_clr(pend_clr), .reg_rdata(reg_rdata)
    );

    alarm_cd_decr u_decr (
        .cur(cnt_q), .nxt(dec_val), .cur_zero(cur_zero), .nxt_zero(nxt_zero)
    );

    alarm_cd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .cnt_wr(cnt_wr),
        .cur_zero(cur_zero), .nxt_zero(nxt_zero),
        .state(state), .dec_fire(dec_fire), .expire(expire)
    );

    assign cnt_word = pack_word(cnt_q);
    assign irq      = pend_q & ie_q;

endmodule

// File: rtl/alarm_cd_check.sv
module alarm_cd_check
    import alarm_cd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              irq,
    input logic [WORD_W-1:0] cnt_word,
    input logic              run,
    input logic              pend,
    input logic              cnt_wr,
    input logic              pend_clr,
    input run_state_t        state
);

    assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_word));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && state == ST_COUNT && !cnt_wr && cnt_word != '0) |=> !$stable(cnt_word));

    assert_zero_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_word == '0 && !cnt_wr) |=> (cnt_word == '0));

    assert_pend_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> (cnt_word == '0));

    assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);

    assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);

    assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_OFF));

    assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF || state == ST_COUNT || state == ST_HALT));

endmodule

bind alarm_countdown alarm_cd_check u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .irq(irq), .cnt_word(cnt_word),
    .run(run_q), .pend(pend_q), .cnt_wr(cnt_wr), .pend_clr(pend_clr), .state(state)
);

// File: tb/sim_alarm_countdown.sv
module sim_alarm_countdown;

    localparam int CLK_PERIOD = 10;
    localparam int DAY_S      = 86400;
    localparam int VEC_N      = 8;
    localparam int V_START [VEC_N] = '{10, 60, 3600, 86400, 5, 3, 90061, 22032000};
    localparam int V_TICKS [VEC_N] = '{3,  1,  1,    1,     5, 7, 2,     1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_countdown u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] word_of(input int secs);
        int d, h, m, s;
        d = secs / DAY_S;
        h = (secs % DAY_S) / 3600;
        m = (secs % 3600) / 60;
        s = secs % 60;
        return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic setup(input int secs, input logic ie);
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h1);
        wr(8'h0C, word_of(secs));
        wr(8'h18, {31'b0, ie});
        wr(8'h14, 32'h100);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'h0C, v); check("R1 count", v, 32'h0);
        rd(8'h14, v); check("R1 run", v, 32'h0);
        rd(8'h18, v); check("R1 irqen", v, 32'h0);
        rd(8'h1C, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2: field layout readback
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); check("R2 readback", v, 32'h1FFF_3F3F);

        // Table-driven countdown: R3 borrow, R5 expiry, R7 irq, R9 long interval
        for (int i = 0; i < VEC_N; i++) begin
            int left;
            setup(V_START[i], 1'b1);
            pulse(V_TICKS[i]);
            left = (V_START[i] > V_TICKS[i]) ? V_START[i] - V_TICKS[i] : 0;
            rd(8'h0C, v); check("R3 count", v, word_of(left));
            rd(8'h1C, v); check("R5 pending", v, {31'b0, left == 0});
            check("R7 irq", {31'b0, irq}, {31'b0, left == 0});
        end

        // R9: 255-day load keeps its day field
        wr(8'h14, 32'h0);
        wr(8'h0C, word_of(255 * DAY_S));
        rd(8'h0C, v); check("R9 day field", (v >> 21) & 32'hFF, 32'd255);

        // R4: ticks ignored while not running, then freeze mid-count
        wr(8'h1C, 32'h1);
        wr(8'h0C, word_of(10));
        pulse(3);
        rd(8'h0C, v); check("R4 idle ticks", v, word_of(10));
        wr(8'h14, 32'h100);
        pulse(2);
        wr(8'h14, 32'h0);
        pulse(3);
        rd(8'h0C, v); check("R4 frozen", v, word_of(8));
        rd(8'h1C, v); check("R4 no pending", v, 32'h0);

        // R8: zero write cancels interval
        setup(5, 1'b1);
        pulse(1);
        wr(8'h0C, 32'h0);
        pulse(3);
        rd(8'h0C, v); check("R8 cancelled", v, 32'h0);
        rd(8'h1C, v); check("R8 no pending", v, 32'h0);

        // R7 and R6: gating and clear-on-one
        setup(2, 1'b0);
        pulse(2);
        check("R7 masked irq", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h1);
        #1; check("R7 unmasked irq", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h0);
        rd(8'h1C, v); check("R6 write zero keeps", v, 32'h1);
        wr(8'h1C, 32'h1);
        rd(8'h1C, v); check("R6 write one clears", v, 32'h0);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);

        // R10: tick in the cycle right after the run write is not counted
        wr(8'h14, 32'h0);
        wr(8'h0C, word_of(20));
        wr(8'h14, 32'h100);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        rd(8'h0C, v); check("R10 early tick", v, word_of(20));
        pulse(1);
        rd(8'h0C, v); check("R10 later tick", v, word_of(19));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule